// File: doc/BRIEF.md
# Configuration-Space Indirect BAR Window

This block is a small register window that sits in a device's configuration space. It lets a driver reach the memory regions behind the device's BARs using configuration reads and writes alone. Software first programs which BAR to target, a byte offset inside that BAR, and an access size of 1, 2 or 4 bytes. It then touches a 4-byte data register. A write to that register pushes the low bytes out to the chosen BAR location. A read from it fetches bytes from that location and returns them in the same configuration read.

The configuration side is a simple request/acknowledge register port with dword addressing. The requester holds `cfg_req_i` high until it sees a one-cycle `cfg_ack_o`. The BAR side is a generic request/acknowledge bus. It carries the BAR index, the byte offset, a byte mask and write data, and it takes a one-cycle acknowledge that comes with read data. Byte 0 of the data register is always carried on bits [7:0] and belongs to the lowest byte address of the access. When the size, the alignment or the BAR index is not usable, the block ignores the data access and sends nothing to the BAR side.

Top module: `cfg_bar_window`

## Requirements
- R1: After reset, word 0 reads 0x0004_0005 and word 1 reads 0, and `bk_req_o` is low. In word 0, bits [7:0] hold the kind code, bits [15:8] the BAR index, bits [23:16] the length, and bits [31:24] read as zero.
- R2: The kind code in word 0 bits [7:0] always reads 5. Writes to those bits have no effect.
- R3: A write to word 0 sets the BAR index (bits [15:8]) and the length (bits [23:16]). A write to word 1 sets the offset (low OFF_W bits). Neither write causes a backend request. The new values are used by the next data access.
- R4: A legal write to word 2 (the data register) issues exactly one backend write. It carries the BAR index, the offset, the byte mask, and the data with unused lanes forced to zero. `cfg_ack_o` comes one cycle after the backend acknowledge.
- R5: A legal read of word 2 issues exactly one backend read. The configuration read returns the acknowledged bytes with the unused upper bytes set to zero. `cfg_ack_o` comes one cycle after the backend acknowledge.
- R6: If the length is anything other than 1, 2 or 4, a data access issues no backend request. A data read then returns 0, and the access is acknowledged one cycle after acceptance.
- R7: If the offset is not a multiple of the length, a data access issues no backend request, and a data read returns 0.
- R8: If the BAR index is NUM_BARS or higher, or its bit in BAR_MASK is clear, a data access issues no backend request, and a data read returns 0.
- R9: The byte mask on `bk_be_o` is 0x1 for length 1, 0x3 for length 2 and 0xF for length 4.
- R10: Only one backend request is outstanding at a time. `bk_req_o` and all its fields stay stable until `bk_ack_i`. No new configuration access is accepted while a request is open, and each configuration access gets exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_req_i | input | 1 | Config access request, held until acknowledged |
| cfg_we_i | input | 1 | Config access is a write |
| cfg_addr_i | input | 2 | Dword index: 0 header, 1 offset, 2 data |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_ack_o | output | 1 | One-cycle completion of a config access |
| cfg_rdata_o | output | 32 | Config read data, valid with cfg_ack_o |
| bk_req_o | output | 1 | Backend request, held until acknowledged |
| bk_we_o | output | 1 | Backend request is a write |
| bk_bar_o | output | 8 | Selected BAR index |
| bk_off_o | output | OFF_W | Byte offset inside the BAR |
| bk_be_o | output | 4 | Byte mask, bit 0 at the lowest address |
| bk_wdata_o | output | 32 | Backend write data, byte 0 on bits [7:0] |
| bk_ack_i | input | 1 | One-cycle backend acknowledge |
| bk_rdata_i | input | 32 | Backend read data, valid with bk_ack_i |

## Verification
The bench builds the block with NUM_BARS = 6, BAR_MASK = 6'b100101 and OFF_W = 16. With these values an unimplemented BAR can be tried both inside the index range (index 1 or 3) and above it (index 7). The bench also varies the backend latency from one to several cycles. A longer latency shows that the configuration acknowledge waits for the fetch, and that the request fields stay unchanged while it waits.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam logic [7:0] WIN_KIND = 8'd5;

  localparam logic [1:0] REG_HDR  = 2'd0;
  localparam logic [1:0] REG_OFF  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  // length code -> byte mask, zero marks an illegal length
  function automatic logic [DATA_BYTES-1:0] len_to_be(input logic [7:0] len);
    case (len)
      8'd1:    return 4'b0001;
      8'd2:    return 4'b0011;
      8'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/cbw_regs.sv
module cbw_regs
  import cbw_pkg::*;
#(
  parameter int                    NUM_BARS = 6,
  parameter logic [NUM_BARS-1:0]   BAR_MASK = 6'b100101,
  parameter int                    OFF_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_hdr_i,
  input  logic                  wr_off_i,
  input  logic [7:0]            bar_wr_i,
  input  logic [7:0]            len_wr_i,
  input  logic [OFF_W-1:0]      off_wr_i,
  output logic [7:0]            bar_q_o,
  output logic [7:0]            len_q_o,
  output logic [OFF_W-1:0]      off_q_o,
  output logic [DATA_BYTES-1:0] be_o,
  output logic                  legal_o
);
  logic bar_ok;
  logic aligned;
  logic [1:0] lo_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q_o <= 8'd0;
      len_q_o <= 8'd4;
    end else if (wr_hdr_i) begin
      bar_q_o <= bar_wr_i;
      len_q_o <= len_wr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q_o <= '0;
    else if (wr_off_i) off_q_o <= off_wr_i;
  end

  assign be_o = len_to_be(len_q_o);

  // low offset bits that must be clear for the programmed size
  assign lo_mask = {be_o[3], be_o[1]};
  assign aligned = (off_q_o[1:0] & lo_mask) == 2'b00;

  always_comb begin
    bar_ok = 1'b0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (bar_q_o == 8'(i) && BAR_MASK[i]) bar_ok = 1'b1;
    end
  end

  assign legal_o = (be_o != '0) && aligned && bar_ok;

  a_r3_hdr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hdr_i |=> $stable(bar_q_o) && $stable(len_q_o));
  a_r3_off_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_off_i |=> $stable(off_q_o));
endmodule

// File: rtl/cbw_lane.sv
module cbw_lane #(
  parameter int NB = 4
) (
  input  logic [NB-1:0]   be_i,
  input  logic [8*NB-1:0] din_i,
  output logic [8*NB-1:0] dout_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout_o[8*b +: 8] = be_i[b] ? din_i[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/cbw_seq.sv
module cbw_seq
  import cbw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_req_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_addr_i,
  input  logic       legal_i,
  input  logic       bk_ack_i,
  output logic       bk_req_o,
  output logic       cfg_ack_o,
  output logic       acc_we_o,
  output logic [1:0] acc_addr_o,
  output logic       wr_hdr_o,
  output logic       wr_off_o,
  output logic       wr_data_o,
  output logic       rd_zero_o,
  output logic       rd_cap_o
);
  seq_st_e st_q, st_d;
  logic    accept;
  logic    is_data;
  logic    acc_legal_q;

  assign accept  = (st_q == ST_IDLE) && cfg_req_i;
  assign is_data = cfg_addr_i == REG_DATA;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = (is_data && legal_i) ? ST_BUSY : ST_DONE;
      ST_BUSY: if (bk_ack_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      acc_we_o    <= 1'b0;
      acc_addr_o  <= REG_HDR;
      acc_legal_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        acc_we_o    <= cfg_we_i;
        acc_addr_o  <= cfg_addr_i;
        acc_legal_q <= legal_i;
      end
    end
  end

  assign bk_req_o  = st_q == ST_BUSY;
  assign cfg_ack_o = st_q == ST_DONE;
  assign wr_hdr_o  = accept && cfg_we_i && (cfg_addr_i == REG_HDR);
  assign wr_off_o  = accept && cfg_we_i && (cfg_addr_i == REG_OFF);
  assign wr_data_o = accept && cfg_we_i && is_data;
  assign rd_zero_o = accept && !cfg_we_i && is_data && !legal_i;
  assign rd_cap_o  = bk_req_o && bk_ack_i && !acc_we_o;

  a_r4_ack_after_bk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o && acc_addr_o == REG_DATA && acc_legal_q |-> $past(bk_ack_i));
  a_r10_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o |=> !cfg_ack_o);
  a_r10_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o |-> !cfg_ack_o);
endmodule

// File: rtl/cfg_bar_window.sv
module cfg_bar_window
  import cbw_pkg::*;
#(
  parameter int                  NUM_BARS = 6,
  parameter logic [NUM_BARS-1:0] BAR_MASK = 6'b100101,
  parameter int                  OFF_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_req_i,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  output logic                  cfg_ack_o,
  output logic [DATA_W-1:0]     cfg_rdata_o,
  output logic                  bk_req_o,
  output logic                  bk_we_o,
  output logic [7:0]            bk_bar_o,
  output logic [OFF_W-1:0]      bk_off_o,
  output logic [DATA_BYTES-1:0] bk_be_o,
  output logic [DATA_W-1:0]     bk_wdata_o,
  input  logic                  bk_ack_i,
  input  logic [DATA_W-1:0]     bk_rdata_i
);
  logic [7:0]        bar_q, len_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_BYTES-1:0] be;
  logic              legal;
  logic              acc_we;
  logic [1:0]        acc_addr;
  logic              wr_hdr, wr_off, wr_data, rd_zero, rd_cap;
  logic [DATA_W-1:0] data_q, rd_masked, rd_mux;

  cbw_regs #(
    .NUM_BARS (NUM_BARS),
    .BAR_MASK (BAR_MASK),
    .OFF_W    (OFF_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hdr_i (wr_hdr),
    .wr_off_i (wr_off),
    .bar_wr_i (cfg_wdata_i[15:8]),
    .len_wr_i (cfg_wdata_i[23:16]),
    .off_wr_i (cfg_wdata_i[OFF_W-1:0]),
    .bar_q_o  (bar_q),
    .len_q_o  (len_q),
    .off_q_o  (off_q),
    .be_o     (be),
    .legal_o  (legal)
  );

  cbw_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_req_i  (cfg_req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .legal_i    (legal),
    .bk_ack_i   (bk_ack_i),
    .bk_req_o   (bk_req_o),
    .cfg_ack_o  (cfg_ack_o),
    .acc_we_o   (acc_we),
    .acc_addr_o (acc_addr),
    .wr_hdr_o   (wr_hdr),
    .wr_off_o   (wr_off),
    .wr_data_o  (wr_data),
    .rd_zero_o  (rd_zero),
    .rd_cap_o   (rd_cap)
  );

  cbw_lane #(.NB(DATA_BYTES)) u_wr_lane (
    .be_i   (be),
    .din_i  (data_q),
    .dout_o (bk_wdata_o)
  );

  cbw_lane #(.NB(DATA_BYTES)) u_rd_lane (
    .be_i   (be),
    .din_i  (bk_rdata_i),
    .dout_o (rd_masked)
  );

  // data register: last written value or last returned read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_data) data_q <= cfg_wdata_i;
    else if (rd_zero) data_q <= '0;
    else if (rd_cap)  data_q <= rd_masked;
  end

  // fields come straight from the registers; port is blocked while busy
  assign bk_we_o  = acc_we;
  assign bk_bar_o = bar_q;
  assign bk_off_o = off_q;
  assign bk_be_o  = be;

  always_comb begin
    case (acc_addr)
      REG_HDR:  rd_mux = {8'h00, len_q, bar_q, WIN_KIND};
      REG_OFF:  rd_mux = DATA_W'(off_q);
      REG_DATA: rd_mux = data_q;
      default:  rd_mux = '0;
    endcase
  end

  assign cfg_rdata_o = (cfg_ack_o && !acc_we) ? rd_mux : '0;

  a_r9_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o |-> (bk_be_o == 4'h1 || bk_be_o == 4'h3 || bk_be_o == 4'hF));
  a_r7_align_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o && bk_be_o == 4'h3 |-> !bk_off_o[0]);
  a_r7_align_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o && bk_be_o == 4'hF |-> bk_off_o[1:0] == 2'b00);
  a_r8_bar_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o |-> bk_bar_o < 8'(NUM_BARS));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o && !bk_ack_i |=> bk_req_o && $stable(bk_we_o) && $stable(bk_bar_o)
      && $stable(bk_off_o) && $stable(bk_be_o) && $stable(bk_wdata_o));
  a_r2_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o && !acc_we && acc_addr == REG_HDR |-> cfg_rdata_o[7:0] == 8'd5);
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o && !acc_we && acc_addr == REG_DATA && len_q == 8'd1
      |-> cfg_rdata_o[31:8] == 24'h0);
endmodule

// File: tb/cfg_bar_window_tb_top.sv
module cfg_bar_window_tb_top;
  localparam int                NUM_BARS = 6;
  localparam logic [NUM_BARS-1:0] BAR_MASK = 6'b100101;
  localparam int                OFF_W    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              cfg_req_i = 0, cfg_we_i = 0;
  logic [1:0]        cfg_addr_i = 0;
  logic [31:0]       cfg_wdata_i = 0;
  logic              cfg_ack_o;
  logic [31:0]       cfg_rdata_o;
  logic              bk_req_o, bk_we_o;
  logic [7:0]        bk_bar_o;
  logic [OFF_W-1:0]  bk_off_o;
  logic [3:0]        bk_be_o;
  logic [31:0]       bk_wdata_o;
  logic              bk_ack_i = 0;
  logic [31:0]       bk_rdata_i = 0;

  cfg_bar_window #(.NUM_BARS(NUM_BARS), .BAR_MASK(BAR_MASK), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_req_i(cfg_req_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_ack_o(cfg_ack_o), .cfg_rdata_o(cfg_rdata_o),
    .bk_req_o(bk_req_o), .bk_we_o(bk_we_o), .bk_bar_o(bk_bar_o), .bk_off_o(bk_off_o),
    .bk_be_o(bk_be_o), .bk_wdata_o(bk_wdata_o), .bk_ack_i(bk_ack_i), .bk_rdata_i(bk_rdata_i)
  );

  int n_tests = 0, n_fail = 0;
  int cur_req = 0;
  int bk_lat  = 1;
  bit cur_rd  = 0;
  logic [7:0] mem [NUM_BARS][64];
  logic [7:0]       t_bar = 0, t_len = 4;
  logic [OFF_W-1:0] t_off = 0;

  typedef struct {
    int req; logic we; logic [7:0] bar; logic [OFF_W-1:0] off;
    logic [3:0] be; logic [31:0] wdata;
  } bk_item_t;
  typedef struct { int req; logic [31:0] val; } rd_item_t;
  bk_item_t bk_q[$];
  rd_item_t rd_q[$];

  task automatic chk(input bit ok, input int req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] tb_be(input logic [7:0] len);
    if (len == 8'd1) return 4'h1;
    if (len == 8'd2) return 4'h3;
    if (len == 8'd4) return 4'hF;
    return 4'h0;
  endfunction

  function automatic bit tb_legal();
    logic [3:0] m;
    m = tb_be(t_len);
    if (m == 4'h0) return 0;
    if ((32'(t_off) % 32'(t_len)) != 0) return 0;
    if (t_bar >= 8'(NUM_BARS)) return 0;
    return BAR_MASK[t_bar[2:0]];
  endfunction

  // backend model and monitor
  bit in_flight = 0;
  int lat_cnt = 0;
  bk_item_t held;
  always @(negedge clk) begin
    if (bk_ack_i) begin
      bk_ack_i = 0;
      in_flight = 0;
    end else if (bk_req_o) begin
      if (!in_flight) begin
        in_flight = 1;
        lat_cnt = 0;
        held = '{cur_req, bk_we_o, bk_bar_o, bk_off_o, bk_be_o, bk_wdata_o};
        if (bk_q.size() == 0) begin
          chk(0, cur_req, {24'h0, bk_bar_o}, 32'hFFFF_FFFF, "unexpected backend access");
        end else begin
          bk_item_t e;
          e = bk_q.pop_front();
          chk(bk_we_o == e.we, e.req, 32'(bk_we_o), 32'(e.we), "backend direction");
          chk(bk_bar_o == e.bar, e.req, 32'(bk_bar_o), 32'(e.bar), "backend bar");
          chk(bk_off_o == e.off, e.req, 32'(bk_off_o), 32'(e.off), "backend offset");
          chk(bk_be_o == e.be, 9, 32'(bk_be_o), 32'(e.be), "backend byte mask R9");
          if (e.we)
            chk(bk_wdata_o == e.wdata, e.req, bk_wdata_o, e.wdata, "backend write data");
        end
      end else begin
        // R10: fields held while waiting
        chk(bk_we_o == held.we && bk_bar_o == held.bar && bk_off_o == held.off &&
            bk_be_o == held.be && bk_wdata_o == held.wdata, 10,
            {bk_be_o, 12'h0, bk_off_o}, {held.be, 12'h0, held.off}, "request fields stable");
      end
      lat_cnt++;
      if (lat_cnt >= bk_lat) begin
        logic [31:0] rd;
        rd = 32'h0;
        for (int i = 0; i < 4; i++) begin
          if (bk_be_o[i] && bk_bar_o < 8'(NUM_BARS)) begin
            if (bk_we_o) mem[bk_bar_o][6'(bk_off_o) + 6'(i)] = bk_wdata_o[8*i +: 8];
            else rd[8*i +: 8] = mem[bk_bar_o][6'(bk_off_o) + 6'(i)];
          end
        end
        bk_rdata_i = bk_we_o ? 32'hDEAD_BEEF : rd;
        bk_ack_i = 1;
      end
    end
  end

  // config read monitor
  always @(negedge clk) begin
    if (cfg_ack_o && cur_rd) begin
      if (rd_q.size() == 0) begin
        chk(0, cur_req, cfg_rdata_o, 32'h0, "unexpected config read completion");
      end else begin
        rd_item_t e;
        e = rd_q.pop_front();
        chk(cfg_rdata_o == e.val, e.req, cfg_rdata_o, e.val, "config read data");
      end
    end
  end

  task automatic cfg_acc(input bit we, input logic [1:0] addr, input logic [31:0] wd,
                         output int waited);
    @(negedge clk);
    cur_rd = !we;
    cfg_req_i = 1; cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = wd;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!cfg_ack_o && waited < 1000);
    if (waited >= 1000) chk(0, 10, 32'(waited), 32'd0, "config ack timeout");
    cfg_req_i = 0;
    @(negedge clk);
    chk(!cfg_ack_o, 10, 32'(cfg_ack_o), 32'd0, "single config ack");
  endtask

  task automatic cfg_wr(input logic [1:0] addr, input logic [31:0] wd);
    int w;
    cfg_acc(1, addr, wd, w);
    chk(w == 1, cur_req, 32'(w), 32'd1, "register write latency");
  endtask

  task automatic cfg_rd_exp(input logic [1:0] addr, input logic [31:0] exp);
    int w;
    rd_q.push_back('{cur_req, exp});
    cfg_acc(0, addr, 32'h0, w);
  endtask

  task automatic set_hdr(input logic [7:0] bar, input logic [7:0] len);
    cfg_wr(2'd0, {8'h00, len, bar, 8'h00});
    t_bar = bar; t_len = len;
  endtask

  task automatic set_off(input logic [OFF_W-1:0] off);
    cfg_wr(2'd1, 32'(off));
    t_off = off;
  endtask

  task automatic data_wr(input logic [31:0] v);
    int w;
    bit lg;
    logic [31:0] m;
    lg = tb_legal();
    m = 32'h0;
    for (int i = 0; i < 4; i++) if (tb_be(t_len)[i]) m[8*i +: 8] = 8'hFF;
    if (lg) bk_q.push_back('{cur_req, 1'b1, t_bar, t_off, tb_be(t_len), v & m});
    cfg_acc(1, 2'd2, v, w);
    chk(w == (lg ? bk_lat + 1 : 1), lg ? 4 : 6, 32'(w), 32'(lg ? bk_lat + 1 : 1),
        "data write ack latency");
  endtask

  task automatic data_rd();
    int w;
    bit lg;
    logic [31:0] e;
    lg = tb_legal();
    e = 32'h0;
    if (lg) begin
      for (int i = 0; i < 4; i++)
        if (tb_be(t_len)[i]) e[8*i +: 8] = mem[t_bar][6'(t_off) + 6'(i)];
      bk_q.push_back('{cur_req, 1'b0, t_bar, t_off, tb_be(t_len), 32'h0});
    end
    rd_q.push_back('{cur_req, e});
    cfg_acc(0, 2'd2, 32'h0, w);
    chk(w == (lg ? bk_lat + 1 : 1), lg ? 5 : 6, 32'(w), 32'(lg ? bk_lat + 1 : 1),
        "data read ack latency");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
  end

  initial begin
    for (int b = 0; b < NUM_BARS; b++)
      for (int a = 0; a < 64; a++) mem[b][a] = 8'(b * 37 + a * 5 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    cur_req = 1;
    chk(!bk_req_o, 1, 32'(bk_req_o), 32'd0, "no backend request after reset");
    chk(!cfg_ack_o, 1, 32'(cfg_ack_o), 32'd0, "no ack after reset");
    cfg_rd_exp(2'd0, 32'h0004_0005);
    cfg_rd_exp(2'd1, 32'h0);

    // R2 kind byte read-only, R3 header/offset programming without backend traffic
    cur_req = 2;
    cfg_wr(2'd0, 32'hAB02_02FF);
    t_bar = 8'd2; t_len = 8'd2;
    cfg_rd_exp(2'd0, 32'h0002_0205);
    cur_req = 3;
    set_off(16'h0010);
    cfg_rd_exp(2'd1, 32'h0000_0010);

    // R4 write, R5 read back, length 2
    bk_lat = 3;
    cur_req = 4;
    data_wr(32'hDDCC_BBAA);
    cur_req = 5;
    data_rd();
    chk(mem[2][16] == 8'hAA && mem[2][17] == 8'hBB && mem[2][18] != 8'hCC, 4,
        {16'h0, mem[2][17], mem[2][16]}, 32'h0000_BBAA, "bytes landed at offset");

    // R9 length 1, R5 upper bytes zero
    bk_lat = 1;
    cur_req = 9;
    set_hdr(8'd0, 8'd1);
    set_off(16'h0013);
    data_wr(32'h1234_5678);
    cur_req = 5;
    data_rd();

    // length 4 on BAR 5
    cur_req = 4;
    set_hdr(8'd5, 8'd4);
    set_off(16'h0020);
    data_wr(32'hCAFE_F00D);
    cur_req = 5;
    data_rd();

    // R7 misalignment
    cur_req = 7;
    set_off(16'h0022);
    data_rd();
    data_wr(32'h1111_1111);
    set_hdr(8'd5, 8'd2);
    set_off(16'h0021);
    data_rd();
    set_hdr(8'd5, 8'd4);
    set_off(16'h0020);
    data_rd();

    // R6 illegal lengths
    cur_req = 6;
    set_hdr(8'd5, 8'd3);
    data_rd();
    set_hdr(8'd5, 8'd0);
    data_wr(32'h2222_2222);
    set_hdr(8'd5, 8'd8);
    data_rd();

    // R8 unimplemented BARs
    cur_req = 8;
    set_off(16'h0000);
    set_hdr(8'd1, 8'd4);
    data_rd();
    set_hdr(8'd7, 8'd4);
    data_rd();
    set_hdr(8'd3, 8'd4);
    data_wr(32'h3333_3333);
    set_hdr(8'd0, 8'd4);
    data_rd();

    // R10 long backend latency
    cur_req = 10;
    bk_lat = 6;
    set_hdr(8'd2, 8'd2);
    set_off(16'h0010);
    data_rd();
    data_wr(32'h0000_5A5A);
    data_rd();

    repeat (5) @(negedge clk);
    chk(bk_q.size() == 0, 10, 32'(bk_q.size()), 32'd0, "backend scoreboard drained");
    chk(rd_q.size() == 0, 5, 32'(rd_q.size()), 32'd0, "read scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, 10, 32'd200000, 32'd0, "watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule